// File: doc/BRIEF.md
# Byte-Stream Block Fetch Requester

This engine pulls a block of data from an external peripheral across two byte-wide channels that carry flow control. A one-cycle start pulse, together with a 32-bit byte address and a 16-bit byte count, opens a transaction. The engine first writes a six-byte read command on the outbound channel. It then takes exactly the requested number of bytes from the inbound channel and presents each one on a local byte output with a one-cycle valid strobe. A done pulse closes the transaction.

On the outbound side the engine writes a byte only in a cycle where the peripheral's full flag is low. On the inbound side it takes a byte only in a cycle where the empty flag is low. Both flags are looked at combinationally in the cycle of the transfer, so a flag that the peripheral raised several cycles earlier is still obeyed. When the flags permit, consecutive cycles can carry transfers with no gap between them. The reset input is asynchronous and active low, and its release is synchronised inside the block.

Top module: `fetch_requester`

## Requirements
- R1: During reset and while idle, `tx_write`, `rx_read`, `out_valid`, `done` and `busy` are all low.
- R2: `tx_write` is high only in a cycle where `tx_full` is low. When `tx_full` stays low, the six command bytes go out on six consecutive cycles.
- R3: The command bytes are sent most significant first: address bits 31:24, 23:16, 15:8 and 7:0, then length bits 15:8 and 7:0. Bit 0 of each byte is on `tx_data[0]`.
- R4: `rx_read` is high only in a cycle where `rx_empty` is low. Exactly `start_len` bytes are read in each transaction. When `rx_empty` stays low, the reads fall on consecutive cycles.
- R5: In the cycle after each `rx_read`, `out_valid` is high and `out_data` holds the byte that `rx_data` carried when it was read.
- R6: `done` pulses for one cycle, in the cycle after the last read. `busy` is already low in that cycle.
- R7: A length of zero still sends all six command bytes. `done` then pulses in the cycle after the sixth write, and `rx_read` never goes high.
- R8: A start pulse that arrives while `busy` is high is ignored. The command and the data count of the running transaction do not change.
- R9: No `rx_read` occurs until all six command bytes of the transaction have been written. `tx_write` and `rx_read` are never high together.
- R10: `busy` rises in the cycle after an accepted start and stays high until the last response byte has been read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse for a transaction |
| start_addr | input | 32 | Byte address to fetch from |
| start_len | input | 16 | Number of bytes to fetch |
| busy | output | 1 | Transaction in progress |
| tx_full | input | 1 | Outbound buffer cannot take a byte |
| tx_data | output | 8 | Outbound command byte |
| tx_write | output | 1 | Outbound write strobe |
| rx_empty | input | 1 | Inbound buffer has no byte |
| rx_data | input | 8 | Inbound response byte |
| rx_read | output | 1 | Inbound read acknowledge |
| out_data | output | 8 | Fetched byte |
| out_valid | output | 1 | `out_data` is valid |
| done | output | 1 | Transaction complete pulse |

## Verification
`tx_write` and `rx_read` depend combinationally on the flags of the same cycle. The bench therefore sets `tx_full`, `rx_empty` and `rx_data` just after each falling edge and, one time unit later, reads the strobes that the next rising edge will act on. `busy`, `out_valid`, `out_data` and `done` each pass through one register, so they are compared at the sample one cycle after their cause: the start, the read, or the final read or write. Per-cycle patterns on the flags move the transfer cycles around. A start pulse during a running transaction, a zero length, and a length above 255 cover the edge cases.

// File: rtl/fetch_req_pkg.sv
package fetch_req_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CMD  = 2'd1,
    ST_RESP = 2'd2
  } fr_state_e;
endpackage

// File: rtl/fetch_rst_sync.sv
module fetch_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/fetch_cmd_mux.sv
// Selects one command byte: the address bytes first, most significant first,
// then the length bytes, most significant first.
module fetch_cmd_mux #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16,
  parameter int BYTE_W = 8,
  localparam int NBYTES = (ADDR_W + LEN_W) / BYTE_W,
  localparam int IDX_W  = $clog2(NBYTES)
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [LEN_W-1:0]  len,
  input  logic [IDX_W-1:0]  idx,
  output logic [BYTE_W-1:0] cmd_byte
);
  localparam int CAT_W = ADDR_W + LEN_W;

  logic [CAT_W-1:0]  cat;
  logic [BYTE_W-1:0] slot [NBYTES];

  assign cat = {addr, len};

  for (genvar g = 0; g < NBYTES; g++) begin : g_slot
    assign slot[g] = cat[(NBYTES-1-g)*BYTE_W +: BYTE_W];
  end

  always_comb begin
    cmd_byte = '0;
    for (int i = 0; i < NBYTES; i++) begin
      if (idx == IDX_W'(i)) cmd_byte = slot[i];
    end
  end
endmodule

// File: rtl/fetch_idx_counter.sv
module fetch_idx_counter #(
  parameter int COUNT = 6,
  localparam int W = $clog2(COUNT)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] idx,
  output logic         last
);
  logic [W-1:0] idx_d;

  always_comb begin
    idx_d = idx;
    if (clr)      idx_d = '0;
    else if (inc) idx_d = idx + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          idx <= '0;
    else if (clr || inc) idx <= idx_d;
  end

  assign last = (idx == W'(COUNT - 1));
endmodule

// File: rtl/fetch_len_counter.sv
module fetch_len_counter #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LEN_W-1:0] load_val,
  input  logic             dec,
  output logic             is_zero,
  output logic             is_one
);
  logic [LEN_W-1:0] rem_q, rem_d;

  always_comb begin
    rem_d = rem_q;
    if (load)     rem_d = load_val;
    else if (dec) rem_d = rem_q - LEN_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           rem_q <= '0;
    else if (load || dec) rem_q <= rem_d;
  end

  assign is_zero = (rem_q == '0);
  assign is_one  = (rem_q == LEN_W'(1));
endmodule

// File: rtl/fetch_ctrl.sv
module fetch_ctrl
  import fetch_req_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic tx_full,
  input  logic rx_empty,
  input  logic idx_last,
  input  logic len_zero,
  input  logic rem_one,
  output logic accept,
  output logic tx_wr,
  output logic rx_rd,
  output logic finish,
  output logic busy
);
  fr_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    accept  = 1'b0;
    tx_wr   = 1'b0;
    rx_rd   = 1'b0;
    finish  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          accept  = 1'b1;
          state_d = ST_CMD;
        end
      end
      ST_CMD: begin
        tx_wr = !tx_full;
        if (tx_wr && idx_last) begin
          if (len_zero) begin
            finish  = 1'b1;
            state_d = ST_IDLE;
          end else begin
            state_d = ST_RESP;
          end
        end
      end
      ST_RESP: begin
        rx_rd = !rx_empty;
        if (rx_rd && rem_one) begin
          finish  = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign busy = (state_q != ST_IDLE);
endmodule

// File: rtl/fetch_requester.sv
module fetch_requester #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16,
  parameter int BYTE_W = 8,
  localparam int NBYTES = (ADDR_W + LEN_W) / BYTE_W,
  localparam int IDX_W  = $clog2(NBYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [LEN_W-1:0]  start_len,
  output logic              busy,
  input  logic              tx_full,
  output logic [BYTE_W-1:0] tx_data,
  output logic              tx_write,
  input  logic              rx_empty,
  input  logic [BYTE_W-1:0] rx_data,
  output logic              rx_read,
  output logic [BYTE_W-1:0] out_data,
  output logic              out_valid,
  output logic              done
);
  logic              rst_i_n;
  logic              accept, finish, idx_last, len_zero, rem_one;
  logic [IDX_W-1:0]  idx;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  len_q;

  fetch_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n)
  );

  fetch_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_i_n), .start(start), .tx_full(tx_full),
    .rx_empty(rx_empty), .idx_last(idx_last), .len_zero(len_zero),
    .rem_one(rem_one), .accept(accept), .tx_wr(tx_write),
    .rx_rd(rx_read), .finish(finish), .busy(busy)
  );

  fetch_idx_counter #(.COUNT(NBYTES)) u_idx (
    .clk(clk), .rst_n(rst_i_n), .clr(accept), .inc(tx_write),
    .idx(idx), .last(idx_last)
  );

  fetch_len_counter #(.LEN_W(LEN_W)) u_len (
    .clk(clk), .rst_n(rst_i_n), .load(accept), .load_val(start_len),
    .dec(rx_read), .is_zero(len_zero), .is_one(rem_one)
  );

  fetch_cmd_mux #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .BYTE_W(BYTE_W)) u_mux (
    .addr(addr_q), .len(len_q), .idx(idx), .cmd_byte(tx_data)
  );

  // Request capture, enabled only on an accepted start.
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      addr_q <= '0;
      len_q  <= '0;
    end else if (accept) begin
      addr_q <= start_addr;
      len_q  <= start_len;
    end
  end

  // Local output stage.
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) out_data <= '0;
    else if (rx_read) out_data <= rx_data;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      out_valid <= 1'b0;
      done      <= 1'b0;
    end else begin
      out_valid <= rx_read;
      done      <= finish;
    end
  end
endmodule

// File: rtl/fetch_requester_chk.sv
module fetch_requester_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       busy,
  input logic       tx_full,
  input logic       tx_write,
  input logic       rx_empty,
  input logic [7:0] rx_data,
  input logic       rx_read,
  input logic [7:0] out_data,
  input logic       out_valid,
  input logic       done
);
  logic [2:0] wr_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_cnt <= '0;
    else if (start && !busy) wr_cnt <= '0;
    else if (tx_write && wr_cnt != 3'd7) wr_cnt <= wr_cnt + 3'd1;
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!tx_write && !rx_read));
  assert_tx_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_write |-> !tx_full);
  assert_rx_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_read |-> !rx_empty);
  assert_valid_follow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(rx_read));
  assert_data_follow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_data == $past(rx_data)));
  assert_done_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
  assert_cmd_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_read |-> (wr_cnt == 3'd6));
  assert_strobe_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_write && rx_read));
  assert_busy_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
endmodule

bind fetch_requester fetch_requester_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .tx_full(tx_full),
  .tx_write(tx_write), .rx_empty(rx_empty), .rx_data(rx_data),
  .rx_read(rx_read), .out_data(out_data), .out_valid(out_valid), .done(done)
);

// File: tb/fetch_requester_test.sv
module fetch_requester_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [31:0] start_addr;
  logic [15:0] start_len;
  logic        busy, tx_full, tx_write, rx_empty, rx_read, out_valid, done;
  logic [7:0]  tx_data, rx_data, out_data;

  always #10 clk = ~clk; // 50 MHz

  fetch_requester uut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .start_len(start_len), .busy(busy), .tx_full(tx_full), .tx_data(tx_data),
    .tx_write(tx_write), .rx_empty(rx_empty), .rx_data(rx_data),
    .rx_read(rx_read), .out_data(out_data), .out_valid(out_valid), .done(done)
  );

  typedef struct packed {
    logic [31:0] addr;
    logic [15:0] len;
    logic [7:0]  full_pat;
    logic [7:0]  empty_pat;
  } vec_t;

  localparam int NVEC = 5;
  localparam vec_t VECS [NVEC] = '{
    '{32'h1234_5678, 16'd4,   8'h00, 8'h00},
    '{32'hA5C3_0F01, 16'd1,   8'h5A, 8'h00},
    '{32'hFFFF_0000, 16'd17,  8'h00, 8'hB6},
    '{32'h0000_00FF, 16'd40,  8'h93, 8'h6D},
    '{32'hDEAD_BEEF, 16'd300, 8'h11, 8'h11}
  };

  int checks = 0, failures = 0;
  int cyc = 0;
  // per-transaction observations
  logic [7:0] tx_log [6];
  int tx_cnt, rd_cnt, out_cnt, out_bad, done_cnt, gate_bad, first_rd_tx;
  int first_wr_cyc, last_wr_cyc, first_rd_cyc, last_rd_cyc, busy_low_early;
  logic pend_rd, pend_last, done_timing_ok;
  logic [7:0] pend_byte;
  int cur_len;
  logic [31:0] cur_addr;

  function automatic logic [7:0] rx_byte(input logic [31:0] a, input int i);
    rx_byte = a[7:0] ^ (8'(i) * 8'd7) ^ 8'(i >> 8);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clear_obs();
    tx_cnt = 0; rd_cnt = 0; out_cnt = 0; out_bad = 0; done_cnt = 0;
    gate_bad = 0; first_rd_tx = -1; first_wr_cyc = -1; last_wr_cyc = -1;
    first_rd_cyc = -1; last_rd_cyc = -1; busy_low_early = 0;
    pend_rd = 1'b0; pend_last = 1'b0; done_timing_ok = 1'b1; pend_byte = '0;
  endtask

  // One clock cycle: drive after the falling edge, then observe.
  task automatic step(input logic st, input logic f, input logic e);
    logic was_last;
    @(negedge clk);
    cyc++;
    start   = st;
    tx_full = f;
    rx_empty = e;
    rx_data = rx_byte(cur_addr, rd_cnt);
    #1;
    // registered outputs reflect the previous cycle
    if (out_valid) begin
      out_cnt++;
      if (!pend_rd || out_data != pend_byte) out_bad++;
    end else if (pend_rd) out_bad++;
    if (done) begin
      done_cnt++;
      if (!pend_last || busy) done_timing_ok = 1'b0;
    end else if (pend_last) done_timing_ok = 1'b0;
    pend_rd = 1'b0; pend_last = 1'b0;
    // combinational strobes for this cycle
    if (tx_write && tx_full) gate_bad++;
    if (rx_read && rx_empty) gate_bad++;
    if (tx_write) begin
      if (tx_cnt < 6) tx_log[tx_cnt] = tx_data;
      tx_cnt++;
      if (first_wr_cyc < 0) first_wr_cyc = cyc;
      last_wr_cyc = cyc;
      if (tx_cnt == 6 && cur_len == 0) pend_last = 1'b1;
    end
    if (rx_read) begin
      if (first_rd_tx < 0) first_rd_tx = tx_cnt;
      if (first_rd_cyc < 0) first_rd_cyc = cyc;
      last_rd_cyc = cyc;
      pend_rd = 1'b1;
      pend_byte = rx_data;
      rd_cnt++;
      was_last = (rd_cnt == cur_len);
      if (was_last) pend_last = 1'b1;
    end
  endtask

  // Runs one transaction; optional extra start pulse at a given cycle offset.
  task automatic run_txn(input logic [31:0] a, input logic [15:0] l,
                         input logic [7:0] fp, input logic [7:0] ep,
                         input int stray_at, input string tag);
    logic [7:0] exp_cmd [6];
    clear_obs();
    cur_addr = a; cur_len = int'(l);
    start_addr = a; start_len = l;
    step(1'b1, 1'b0, 1'b1);
    step(1'b0, fp[cyc % 8], ep[cyc % 8]);
    check(busy == 1'b1, "R10", {tag, " busy after start"}, busy, 1);
    for (int k = 0; k < 4000 && done_cnt == 0; k++) begin
      if (k == stray_at) begin
        start_addr = ~a; start_len = l + 16'd3;
      end
      step(k == stray_at, fp[cyc % 8], ep[cyc % 8]);
      if (done_cnt == 0 && !busy && !pend_last) busy_low_early++;
    end
    step(1'b0, 1'b0, 1'b1); // trailing cycle: nothing more may happen
    exp_cmd = '{a[31:24], a[23:16], a[15:8], a[7:0], l[15:8], l[7:0]};
    check(tx_cnt == 6, "R3", {tag, " command byte count"}, tx_cnt, 6);
    for (int i = 0; i < 6; i++)
      check(tx_log[i] == exp_cmd[i], "R3", {tag, " command byte"},
            tx_log[i], exp_cmd[i]);
    check(gate_bad == 0, "R2/R4", {tag, " strobe while flag set"}, gate_bad, 0);
    check(rd_cnt == cur_len, "R4", {tag, " read count"}, rd_cnt, cur_len);
    check(out_cnt == cur_len && out_bad == 0, "R5", {tag, " output bytes"},
          out_bad, 0);
    check(done_cnt == 1 && done_timing_ok, "R6", {tag, " done pulse"},
          done_cnt, 1);
    check(busy_low_early == 0, "R10", {tag, " busy held"}, busy_low_early, 0);
    if (cur_len > 0)
      check(first_rd_tx == 6, "R9", {tag, " writes before first read"},
            first_rd_tx, 6);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; start_addr = '0; start_len = '0;
    tx_full = 1'b0; rx_empty = 1'b1; rx_data = '0;
    cur_addr = '0; cur_len = 0;
    clear_obs();
    repeat (3) @(negedge clk);
    #1;
    // R1: reset state
    check(!tx_write && !rx_read && !out_valid && !done && !busy, "R1",
          "outputs in reset", {tx_write, rx_read, out_valid, done, busy}, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) step(1'b0, 1'b0, 1'b0);
    check(!tx_write && !rx_read && !busy, "R1", "idle outputs",
          {tx_write, rx_read, busy}, 0);

    // Vector table
    for (int v = 0; v < NVEC; v++)
      run_txn(VECS[v].addr, VECS[v].len, VECS[v].full_pat,
              VECS[v].empty_pat, -1, $sformatf("vec%0d", v));

    // R2/R4: back-to-back timing with flags clear
    run_txn(32'h0102_0304, 16'd5, 8'h00, 8'h00, -1, "b2b");
    check(last_wr_cyc - first_wr_cyc == 5, "R2", "six writes back to back",
          last_wr_cyc - first_wr_cyc, 5);
    check(last_rd_cyc - first_rd_cyc == 4, "R4", "five reads back to back",
          last_rd_cyc - first_rd_cyc, 4);

    // R7: zero length
    run_txn(32'h7654_3210, 16'd0, 8'h24, 8'h00, -1, "zero_len R7");
    check(rd_cnt == 0, "R7", "no reads for zero length", rd_cnt, 0);

    // R8: start while busy is ignored (during command and during response)
    run_txn(32'h0BAD_F00D, 16'd6, 8'h00, 8'h00, 2, "stray_cmd R8");
    run_txn(32'h00C0_FFEE, 16'd9, 8'h00, 8'h44, 10, "stray_resp R8");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule